// File: doc/BRIEF.md
# Programmable Memory Pointer Unit

This unit sits between a 16-bit DSP core and three word-wide memories: a large ROM, a DRAM and a small internal instruction RAM. It holds a bank of read pointers and a bank of write pointers. Each pointer is 32 bits: a mode word in the upper half and an address in the lower half. When the core moves a word through a pointer, the unit decodes the mode word against fixed masks. That decode picks the target memory and the access flavour. The unit then moves one word and advances the pointer by a step that depends on the mode.

Pointers are programmed through one shared 32-bit control register, which takes two accesses to load. The first access loads the address half. The second loads the mode half and arms a programming step. The next pointer access then copies the whole control register into the chosen pointer instead of moving data. After every real data access, the control register holds the post-step value of the pointer just used, so the core can read it back.

All three memories are modelled as synchronous word ports: read data arrives one cycle after the read strobe. A partial-nibble DRAM write reads the old word first and writes the merged word one cycle later. During that second cycle, `busy_o` is high and the unit ignores new requests.

Top module: `pm_pointer_unit`

## Requirements
- R1: A control-register write (kind 3) with no address pending loads the write data into the low half and sets address-pending. With address-pending set, the write loads the high half, clears address-pending and sets programming-pending.
- R2: A control-register read (kind 2) with no address pending returns the low half and sets address-pending. With address-pending set, the read returns the high half, clears address-pending and sets programming-pending.
- R3: While programming-pending is set, a pointer read (kind 0) or pointer write (kind 1) does three things:
  - it copies the whole control register into the selected pointer;
  - it touches no memory;
  - it clears programming-pending.
  A pointer read in this case returns zero.
- R4: A real pointer access clears address-pending. Afterwards the control register equals the post-step value of the pointer used.
- R5: A pointer read whose mode satisfies (mode & 0xFFF0) == 0x0800 reads ROM at pointer bits [19:0]. The pointer then adds 1 as a 32-bit value, so the address carries into the mode half.
- R6: A pointer read whose mode satisfies (mode & 0x47FF) == 0x0018 reads DRAM at pointer bits [15:0]. The pointer then steps by the code in mode bits [13:11]: codes 0..7 give 0, 1, 2, 4, 8, 16, 32 and 128.
- R7: A pointer write whose mode satisfies (mode & 0x43FF) == 0x0018 stores the word to DRAM. The pointer then steps by the bits [13:11] code.
- R8: In a DRAM write, mode bit 10 selects nibble merge: each non-zero nibble of the new word replaces the stored nibble, and zero nibbles keep the old value. The old word is read in the access cycle. The merged word is written one cycle later, with `busy_o` high for exactly that one cycle.
- R9: A pointer write whose mode satisfies (mode & 0xFBFF) == 0x4018 stores to DRAM. The pointer then advances by 31 if the address was odd, or by 1 if it was even.
- R10: A pointer write whose mode satisfies (mode & 0x47FF) == 0x001C stores to the instruction RAM at address bits [9:0]. The pointer then steps by the bits [13:11] code.
- R11: A pointer access with a mode that matches no rule touches no memory and leaves the pointer unchanged. A read of this kind returns zero.
- R12: The flag-clear request (kind 4) clears both address-pending and programming-pending.
- R13: Read data and `rvalid_o` appear exactly one cycle after an accepted pointer read or control read. At most one memory strobe is active per cycle. Requests with a pointer index of 5 or more, or with kinds 5 to 7, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Request strobe |
| acc_kind_i | input | 3 | 0 ptr read, 1 ptr write, 2 ctrl read, 3 ctrl write, 4 clear flags |
| acc_ptr_i | input | 3 | Pointer index |
| acc_wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Merge-write cycle; requests ignored |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_addr_o | output | 20 | ROM word address |
| rom_rdata_i | input | 16 | ROM data, one cycle after strobe |
| dram_rd_o | output | 1 | DRAM read strobe |
| dram_wr_o | output | 1 | DRAM write strobe |
| dram_addr_o | output | 16 | DRAM word address |
| dram_wdata_o | output | 16 | DRAM write data |
| dram_rdata_i | input | 16 | DRAM data, one cycle after strobe |
| iram_wr_o | output | 1 | Instruction RAM write strobe |
| iram_addr_o | output | 10 | Instruction RAM word address |
| iram_wdata_o | output | 16 | Instruction RAM write data |

## Verification
The bench checks the three control-register toggles:
- a design that ignores address-pending loads the mode into the address half;
- a design that never clears it after a data access makes the next control read return the mode instead of the address.

The ROM pointer is run across a 16-bit address boundary, which catches a design that steps only the low half. The odd/even cell stepping is checked: a swapped step sends the second write to 0x302 instead of 0x320. The nibble merge uses zero nibbles on both sides, which catches a design that merges the wrong way or writes the raw word. Instruction RAM addresses are checked across the 10-bit wrap. Unmatched modes and out-of-range indices are checked for memory strobes and for changes to the pointers.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 2 * DATA_W;

  typedef enum logic [2:0] {
    KIND_PTR_RD = 3'd0,
    KIND_PTR_WR = 3'd1,
    KIND_CTL_RD = 3'd2,
    KIND_CTL_WR = 3'd3,
    KIND_CLR    = 3'd4
  } acc_kind_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ROM,
    TGT_DRAM,
    TGT_DRAM_CELL,
    TGT_IRAM
  } tgt_e;

  typedef enum logic [1:0] {
    RSRC_HOLD,
    RSRC_ROM,
    RSRC_DRAM
  } rsrc_e;

  localparam logic [15:0] ROM_RD_MASK   = 16'hFFF0;
  localparam logic [15:0] ROM_RD_MATCH  = 16'h0800;
  localparam logic [15:0] DRAM_RD_MASK  = 16'h47FF;
  localparam logic [15:0] DRAM_RD_MATCH = 16'h0018;
  localparam logic [15:0] DRAM_WR_MASK  = 16'h43FF;
  localparam logic [15:0] DRAM_WR_MATCH = 16'h0018;
  localparam logic [15:0] CELL_WR_MASK  = 16'hFBFF;
  localparam logic [15:0] CELL_WR_MATCH = 16'h4018;
  localparam logic [15:0] IRAM_WR_MASK  = 16'h47FF;
  localparam logic [15:0] IRAM_WR_MATCH = 16'h001C;
  localparam int          OVR_BIT       = 10;

  function automatic logic [7:0] step_of(input logic [2:0] code);
    logic [7:0] s;
    case (code)
      3'd0:    s = 8'd0;
      3'd7:    s = 8'd128;
      default: s = 8'd1 << (code - 3'd1);
    endcase
    return s;
  endfunction

  // non-zero nibbles of nw replace the matching nibbles of old
  function automatic logic [DATA_W-1:0] merge_nibbles(input logic [DATA_W-1:0] old,
                                                      input logic [DATA_W-1:0] nw);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W / 4; i++) begin
      r[i*4 +: 4] = (nw[i*4 +: 4] != 4'h0) ? nw[i*4 +: 4] : old[i*4 +: 4];
    end
    return r;
  endfunction
endpackage

// File: rtl/pmu_decode.sv
module pmu_decode
  import pmu_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             is_wr_i,
  output tgt_e             tgt_o,
  output logic             ovr_o,
  output logic [PTR_W-1:0] nxt_o
);
  logic [DATA_W-1:0] mode;
  logic [7:0]        step;

  assign mode = ptr_i[PTR_W-1:DATA_W];

  always_comb begin
    tgt_o = TGT_NONE;
    ovr_o = 1'b0;
    step  = 8'd0;
    if (!is_wr_i) begin
      if ((mode & ROM_RD_MASK) == ROM_RD_MATCH) begin
        tgt_o = TGT_ROM;
        step  = 8'd1;
      end else if ((mode & DRAM_RD_MASK) == DRAM_RD_MATCH) begin
        tgt_o = TGT_DRAM;
        step  = step_of(mode[13:11]);
      end
    end else begin
      if ((mode & DRAM_WR_MASK) == DRAM_WR_MATCH) begin
        tgt_o = TGT_DRAM;
        ovr_o = mode[OVR_BIT];
        step  = step_of(mode[13:11]);
      end else if ((mode & CELL_WR_MASK) == CELL_WR_MATCH) begin
        tgt_o = TGT_DRAM_CELL;
        ovr_o = mode[OVR_BIT];
        step  = ptr_i[0] ? 8'd31 : 8'd1;
      end else if ((mode & IRAM_WR_MASK) == IRAM_WR_MATCH) begin
        tgt_o = TGT_IRAM;
        step  = step_of(mode[13:11]);
      end
    end
  end

  // full-width add: address carries into the mode half
  assign nxt_o = ptr_i + PTR_W'(step);
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              ctl_rd_i,
  input  logic              clr_i,
  input  logic              prog_take_i,
  input  logic              data_acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  post_ptr_i,
  output logic [PTR_W-1:0]  ctrl_o,
  output logic              addr_pend_o,
  output logic              prog_pend_o,
  output logic [DATA_W-1:0] rd_half_o
);
  logic [PTR_W-1:0] ctrl_q;
  logic             addr_pend_q, prog_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      addr_pend_q <= 1'b0;
      prog_pend_q <= 1'b0;
    end else if (clr_i) begin
      addr_pend_q <= 1'b0;
      prog_pend_q <= 1'b0;
    end else if (ctl_wr_i) begin
      if (!addr_pend_q) begin
        ctrl_q[DATA_W-1:0] <= wdata_i;
        addr_pend_q        <= 1'b1;
      end else begin
        ctrl_q[PTR_W-1:DATA_W] <= wdata_i;
        addr_pend_q            <= 1'b0;
        prog_pend_q            <= 1'b1;
      end
    end else if (ctl_rd_i) begin
      if (!addr_pend_q) begin
        addr_pend_q <= 1'b1;
      end else begin
        addr_pend_q <= 1'b0;
        prog_pend_q <= 1'b1;
      end
    end else if (prog_take_i) begin
      prog_pend_q <= 1'b0;
    end else if (data_acc_i) begin
      ctrl_q      <= post_ptr_i;
      addr_pend_q <= 1'b0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign addr_pend_o = addr_pend_q;
  assign prog_pend_o = prog_pend_q;
  assign rd_half_o   = addr_pend_q ? ctrl_q[PTR_W-1:DATA_W] : ctrl_q[DATA_W-1:0];
endmodule

// File: rtl/pmu_ptr_bank.sv
module pmu_ptr_bank
  import pmu_pkg::*;
#(
  parameter int NUM_PTRS = 5,
  parameter int IDX_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             side_wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upd_en_i,
  input  logic [PTR_W-1:0] upd_val_i,
  output logic [PTR_W-1:0] cur_o
);
  logic [PTR_W-1:0] rd_ptr_q [NUM_PTRS];
  logic [PTR_W-1:0] wr_ptr_q [NUM_PTRS];

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
    logic hit;
    assign hit = upd_en_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_ptr_q[g] <= '0;
        wr_ptr_q[g] <= '0;
      end else if (hit) begin
        if (side_wr_i) wr_ptr_q[g] <= upd_val_i;
        else           rd_ptr_q[g] <= upd_val_i;
      end
    end
  end

  always_comb begin
    cur_o = '0;
    for (int i = 0; i < NUM_PTRS; i++) begin
      if (idx_i == IDX_W'(i)) cur_o = side_wr_i ? wr_ptr_q[i] : rd_ptr_q[i];
    end
  end
endmodule

// File: rtl/pm_pointer_unit.sv
module pm_pointer_unit
  import pmu_pkg::*;
#(
  parameter int NUM_PTRS = 5,
  parameter int ROM_AW   = 20,
  parameter int DRAM_AW  = 16,
  parameter int IRAM_AW  = 10,
  localparam int IDX_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS + 1) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [2:0]         acc_kind_i,
  input  logic [IDX_W-1:0]   acc_ptr_i,
  input  logic [15:0]        acc_wdata_i,
  output logic [15:0]        rdata_o,
  output logic               rvalid_o,
  output logic               busy_o,
  output logic               rom_rd_o,
  output logic [ROM_AW-1:0]  rom_addr_o,
  input  logic [15:0]        rom_rdata_i,
  output logic               dram_rd_o,
  output logic               dram_wr_o,
  output logic [DRAM_AW-1:0] dram_addr_o,
  output logic [15:0]        dram_wdata_o,
  input  logic [15:0]        dram_rdata_i,
  output logic               iram_wr_o,
  output logic [IRAM_AW-1:0] iram_addr_o,
  output logic [15:0]        iram_wdata_o
);
  logic accept, idx_ok, is_wr, ptr_acc, prog_take, data_acc;
  logic ctl_rd, ctl_wr, clr, rd_req;
  logic addr_pend, prog_pend, ovr;
  logic [PTR_W-1:0]  ctrl, cur_ptr, nxt_ptr;
  logic [DATA_W-1:0] ctl_half;
  tgt_e tgt;

  logic               busy_q, rvalid_q;
  logic [DRAM_AW-1:0] ovr_addr_q;
  logic [DATA_W-1:0]  ovr_data_q, rhold_q;
  rsrc_e              rsrc_q, rsrc_d;

  assign accept    = acc_valid_i && !busy_q;
  assign idx_ok    = acc_ptr_i < IDX_W'(NUM_PTRS);
  assign is_wr     = acc_kind_i == KIND_PTR_WR;
  assign ptr_acc   = accept && idx_ok && (acc_kind_i == KIND_PTR_RD || is_wr);
  assign prog_take = ptr_acc && prog_pend;
  assign data_acc  = ptr_acc && !prog_pend;
  assign ctl_rd    = accept && acc_kind_i == KIND_CTL_RD;
  assign ctl_wr    = accept && acc_kind_i == KIND_CTL_WR;
  assign clr       = accept && acc_kind_i == KIND_CLR;
  assign rd_req    = ctl_rd || (ptr_acc && !is_wr);

  pmu_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_wr_i    (ctl_wr),
    .ctl_rd_i    (ctl_rd),
    .clr_i       (clr),
    .prog_take_i (prog_take),
    .data_acc_i  (data_acc),
    .wdata_i     (acc_wdata_i),
    .post_ptr_i  (nxt_ptr),
    .ctrl_o      (ctrl),
    .addr_pend_o (addr_pend),
    .prog_pend_o (prog_pend),
    .rd_half_o   (ctl_half)
  );

  pmu_ptr_bank #(.NUM_PTRS(NUM_PTRS), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .side_wr_i (is_wr),
    .idx_i     (acc_ptr_i),
    .upd_en_i  (prog_take || (data_acc && tgt != TGT_NONE)),
    .upd_val_i (prog_take ? ctrl : nxt_ptr),
    .cur_o     (cur_ptr)
  );

  pmu_decode u_dec (
    .ptr_i   (cur_ptr),
    .is_wr_i (is_wr),
    .tgt_o   (tgt),
    .ovr_o   (ovr),
    .nxt_o   (nxt_ptr)
  );

  logic dram_tgt;
  assign dram_tgt = tgt == TGT_DRAM || tgt == TGT_DRAM_CELL;

  // memory strobes
  assign rom_rd_o     = data_acc && !is_wr && tgt == TGT_ROM;
  assign rom_addr_o   = cur_ptr[ROM_AW-1:0];
  assign dram_rd_o    = data_acc && dram_tgt && (!is_wr || ovr);
  assign dram_wr_o    = busy_q || (data_acc && is_wr && dram_tgt && !ovr);
  assign dram_addr_o  = busy_q ? ovr_addr_q : cur_ptr[DRAM_AW-1:0];
  assign dram_wdata_o = busy_q ? merge_nibbles(dram_rdata_i, ovr_data_q) : acc_wdata_i;
  assign iram_wr_o    = data_acc && is_wr && tgt == TGT_IRAM;
  assign iram_addr_o  = cur_ptr[IRAM_AW-1:0];
  assign iram_wdata_o = acc_wdata_i;

  always_comb begin
    rsrc_d = RSRC_HOLD;
    if (data_acc && !is_wr) begin
      if (tgt == TGT_ROM)       rsrc_d = RSRC_ROM;
      else if (tgt == TGT_DRAM) rsrc_d = RSRC_DRAM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ovr_addr_q <= '0;
      ovr_data_q <= '0;
      rvalid_q   <= 1'b0;
      rsrc_q     <= RSRC_HOLD;
      rhold_q    <= '0;
    end else begin
      busy_q   <= data_acc && is_wr && dram_tgt && ovr;
      rvalid_q <= rd_req;
      if (data_acc && is_wr) begin
        ovr_addr_q <= cur_ptr[DRAM_AW-1:0];
        ovr_data_q <= acc_wdata_i;
      end
      if (rd_req) begin
        rsrc_q  <= rsrc_d;
        rhold_q <= ctl_rd ? ctl_half : '0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rvalid_q) begin
      case (rsrc_q)
        RSRC_ROM:  rdata_o = rom_rdata_i;
        RSRC_DRAM: rdata_o = dram_rdata_i;
        default:   rdata_o = rhold_q;
      endcase
    end
  end

  assign rvalid_o = rvalid_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int IDX_W    = 3,
  parameter int NUM_PTRS = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [2:0]       acc_kind_i,
  input logic [IDX_W-1:0] acc_ptr_i,
  input logic             rvalid_o,
  input logic             busy_o,
  input logic             rom_rd_o,
  input logic             dram_rd_o,
  input logic             dram_wr_o,
  input logic             iram_wr_o,
  input logic             addr_pend_i,
  input logic             prog_pend_i
);
  logic acc_ok, idx_ok, ptr_kind, rd_kind;
  assign acc_ok   = acc_valid_i && !busy_o;
  assign idx_ok   = acc_ptr_i < IDX_W'(NUM_PTRS);
  assign ptr_kind = (acc_kind_i == 3'd0 || acc_kind_i == 3'd1) && idx_ok;
  assign rd_kind  = (acc_kind_i == 3'd0 && idx_ok) || acc_kind_i == 3'd2;

  assert_ctl_wr_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && acc_kind_i == 3'd3 && !addr_pend_i |=> addr_pend_i);

  assert_prog_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && ptr_kind && prog_pend_i |-> !(rom_rd_o || dram_rd_o || dram_wr_o || iram_wr_o));

  assert_prog_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && ptr_kind && prog_pend_i |=> !prog_pend_i);

  assert_busy_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  assert_busy_writes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> dram_wr_o && $past(dram_rd_o));

  assert_clear_flags_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && acc_kind_i == 3'd4 |=> !addr_pend_i && !prog_pend_i);

  assert_rvalid_follows_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && rd_kind |=> rvalid_o);

  assert_rvalid_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_ok && rd_kind) |=> !rvalid_o);

  assert_one_port_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_rd_o, dram_rd_o, dram_wr_o, iram_wr_o}));
endmodule

bind pm_pointer_unit pmu_checker #(.IDX_W(IDX_W), .NUM_PTRS(NUM_PTRS)) u_pmu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_kind_i  (acc_kind_i),
  .acc_ptr_i   (acc_ptr_i),
  .rvalid_o    (rvalid_o),
  .busy_o      (busy_o),
  .rom_rd_o    (rom_rd_o),
  .dram_rd_o   (dram_rd_o),
  .dram_wr_o   (dram_wr_o),
  .iram_wr_o   (iram_wr_o),
  .addr_pend_i (addr_pend),
  .prog_pend_i (prog_pend)
);

// File: tb/test_pm_pointer_unit.sv
module test_pm_pointer_unit;
  localparam logic [2:0] K_PRD = 3'd0, K_PWR = 3'd1, K_CRD = 3'd2, K_CWR = 3'd3, K_CLR = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_kind = '0;
  logic [2:0]  acc_ptr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] rdata, dram_wdata, iram_wdata;
  logic        rvalid, busy, rom_rd, dram_rd, dram_wr, iram_wr;
  logic [19:0] rom_addr;
  logic [15:0] dram_addr;
  logic [9:0]  iram_addr;
  logic [15:0] rom_q = '0, dram_q = '0;

  int checks = 0, failures = 0;
  int rom_cnt = 0, dram_rd_cnt = 0, dram_wr_cnt = 0, iram_cnt = 0;
  logic [19:0] last_rom_addr = '0;
  logic [15:0] last_dram_waddr = '0, last_dram_wdata = '0;
  logic [9:0]  last_iram_addr = '0;
  logic        saw_busy;
  logic [15:0] dram_m [4096];
  logic [15:0] iram_m [1024];

  always #5 clk = ~clk;

  function automatic logic [15:0] rom_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h000} ^ 16'hC3A5;
  endfunction

  pm_pointer_unit i_pm_pointer_unit (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_kind_i(acc_kind),
    .acc_ptr_i(acc_ptr), .acc_wdata_i(acc_wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .busy_o(busy), .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_rdata_i(rom_q),
    .dram_rd_o(dram_rd), .dram_wr_o(dram_wr), .dram_addr_o(dram_addr),
    .dram_wdata_o(dram_wdata), .dram_rdata_i(dram_q), .iram_wr_o(iram_wr),
    .iram_addr_o(iram_addr), .iram_wdata_o(iram_wdata)
  );

  always @(posedge clk) begin
    if (rom_rd) begin
      rom_q <= rom_word(rom_addr);
      rom_cnt <= rom_cnt + 1;
      last_rom_addr <= rom_addr;
    end
    if (dram_rd) begin
      dram_q <= dram_m[dram_addr[11:0]];
      dram_rd_cnt <= dram_rd_cnt + 1;
    end
    if (dram_wr) begin
      dram_m[dram_addr[11:0]] <= dram_wdata;
      dram_wr_cnt <= dram_wr_cnt + 1;
      last_dram_waddr <= dram_addr;
      last_dram_wdata <= dram_wdata;
    end
    if (iram_wr) begin
      iram_m[iram_addr] <= iram_wdata;
      iram_cnt <= iram_cnt + 1;
      last_iram_addr <= iram_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] k, input logic [2:0] idx, input logic [15:0] wd,
                     output logic rv, output logic [15:0] rd);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_ptr = idx; acc_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    rv = rvalid; rd = rdata; saw_busy = busy;
    while (busy) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [2:0] side, input logic [2:0] idx,
                         input logic [15:0] mode, input logic [15:0] addr);
    logic rv; logic [15:0] rd; int rc, dc, ic;
    acc(K_CWR, 0, addr, rv, rd);
    acc(K_CWR, 0, mode, rv, rd);
    rc = rom_cnt; dc = dram_rd_cnt + dram_wr_cnt; ic = iram_cnt;
    acc(side, idx, 16'hFFFF, rv, rd);
    check("R3 program access touches no memory", 32'(rom_cnt + dram_rd_cnt + dram_wr_cnt + iram_cnt),
          32'(rc + dc + ic));
    if (side == K_PRD) check("R3 program read returns zero", {rv, rd}, {1'b1, 16'h0});
  endtask

  // reads the low control half after a data access, then clears the flags
  task automatic ctl_low(input string req, input logic [15:0] exp);
    logic rv; logic [15:0] rd;
    acc(K_CRD, 0, 0, rv, rd);
    check(req, {rv, rd}, {1'b1, exp});
    acc(K_CLR, 0, 0, rv, rd);
  endtask

  task automatic t_reset;
    logic rv; logic [15:0] rd;
    check("R13 reset outputs idle", {rvalid, busy, rom_rd, dram_rd, dram_wr, iram_wr}, 0);
    acc(K_CRD, 0, 0, rv, rd);
    check("R2 control reads zero after reset", {rv, rd}, {1'b1, 16'h0});
    acc(K_CLR, 0, 0, rv, rd);
  endtask

  task automatic t_rom;
    logic rv; logic [15:0] rd;
    set_ptr(K_PRD, 2, 16'h0800, 16'h0010);
    acc(K_CWR, 0, 16'hBEEF, rv, rd);
    acc(K_PRD, 2, 0, rv, rd);
    check("R5 R13 rom read data", {rv, rd}, {1'b1, rom_word(20'h00010)});
    ctl_low("R4 control holds stepped pointer, address flag cleared", 16'h0011);
    acc(K_PRD, 2, 0, rv, rd);
    check("R5 rom second read", rd, rom_word(20'h00011));
    check("R5 rom address", last_rom_addr, 20'h00011);
    acc(K_CRD, 0, 0, rv, rd);
    check("R2 first control read gives address", rd, 16'h0012);
    acc(K_CRD, 0, 0, rv, rd);
    check("R2 second control read gives mode", rd, 16'h0800);
    acc(K_PRD, 0, 0, rv, rd);
    check("R3 programming read via control reads returns zero", {rv, rd}, {1'b1, 16'h0});
    acc(K_PRD, 0, 0, rv, rd);
    check("R3 copied pointer used", rd, rom_word(20'h00012));
    set_ptr(K_PRD, 1, 16'h0800, 16'hFFFF);
    acc(K_PRD, 1, 0, rv, rd);
    check("R5 rom before carry", rd, rom_word(20'h0FFFF));
    acc(K_PRD, 1, 0, rv, rd);
    check("R5 rom after carry data", rd, rom_word(20'h10000));
    check("R5 rom after carry address", last_rom_addr, 20'h10000);
  endtask

  task automatic t_dram;
    logic rv; logic [15:0] rd; int wc;
    set_ptr(K_PWR, 3, 16'h0818, 16'h0100);
    wc = dram_wr_cnt;
    for (int i = 0; i < 8; i++) acc(K_PWR, 3, 16'h1000 + 16'(i), rv, rd);
    check("R7 dram write count", 32'(dram_wr_cnt - wc), 32'd8);
    check("R7 dram last write address", last_dram_waddr, 16'h0107);
    ctl_low("R7 dram write pointer stepped", 16'h0108);
    set_ptr(K_PRD, 4, 16'h1818, 16'h0100);
    acc(K_PRD, 4, 0, rv, rd);
    check("R6 dram read first", {rv, rd}, {1'b1, 16'h1000});
    acc(K_PRD, 4, 0, rv, rd);
    check("R6 dram read step 4", rd, 16'h1004);
    set_ptr(K_PRD, 4, 16'h3818, 16'h0100);
    acc(K_PRD, 4, 0, rv, rd);
    ctl_low("R6 code 7 steps by 128", 16'h0180);
  endtask

  task automatic t_ovr;
    logic rv; logic [15:0] rd;
    set_ptr(K_PWR, 0, 16'h0C18, 16'h0104);
    acc(K_PWR, 0, 16'hA0B0, rv, rd);
    check("R8 busy during merge", saw_busy, 1'b1);
    check("R8 merged word", {last_dram_waddr, last_dram_wdata}, {16'h0104, 16'hA0B4});
    set_ptr(K_PRD, 4, 16'h0018, 16'h0104);
    acc(K_PRD, 4, 0, rv, rd);
    acc(K_PRD, 4, 0, rv, rd);
    check("R8 R6 merged word readback with step 0", rd, 16'hA0B4);
    check("R8 busy released", busy, 1'b0);
  endtask

  task automatic t_cell;
    logic rv; logic [15:0] rd;
    set_ptr(K_PWR, 1, 16'h4018, 16'h0301);
    acc(K_PWR, 1, 16'h0001, rv, rd);
    check("R9 cell first address", last_dram_waddr, 16'h0301);
    acc(K_PWR, 1, 16'h0002, rv, rd);
    check("R9 odd address steps 31", last_dram_waddr, 16'h0320);
    acc(K_PWR, 1, 16'h0003, rv, rd);
    check("R9 even address steps 1", last_dram_waddr, 16'h0321);
  endtask

  task automatic t_iram;
    logic rv; logic [15:0] rd;
    set_ptr(K_PWR, 2, 16'h101C, 16'h07FE);
    acc(K_PWR, 2, 16'h5555, rv, rd);
    check("R10 iram low 10 bits", last_iram_addr, 10'h3FE);
    acc(K_PWR, 2, 16'h6666, rv, rd);
    check("R10 iram wraps", last_iram_addr, 10'h000);
    check("R10 iram data", iram_m[0], 16'h6666);
    ctl_low("R10 iram pointer stepped by 2", 16'h0802);
  endtask

  task automatic t_unmatched;
    logic rv; logic [15:0] rd; int n;
    set_ptr(K_PWR, 4, 16'h0000, 16'h0050);
    n = rom_cnt + dram_rd_cnt + dram_wr_cnt + iram_cnt;
    acc(K_PWR, 4, 16'h7777, rv, rd);
    check("R11 unmatched write no memory", 32'(rom_cnt + dram_rd_cnt + dram_wr_cnt + iram_cnt), 32'(n));
    ctl_low("R11 unmatched write pointer unchanged", 16'h0050);
    set_ptr(K_PRD, 3, 16'h0019, 16'h0050);
    acc(K_PRD, 3, 0, rv, rd);
    check("R11 unmatched read returns zero", {rv, rd}, {1'b1, 16'h0});
    check("R11 unmatched read no memory", 32'(rom_cnt + dram_rd_cnt + dram_wr_cnt + iram_cnt), 32'(n));
    ctl_low("R11 unmatched read pointer unchanged", 16'h0050);
  endtask

  task automatic t_clear;
    logic rv; logic [15:0] rd;
    acc(K_CWR, 0, 16'h1111, rv, rd);
    acc(K_CLR, 0, 0, rv, rd);
    acc(K_CWR, 0, 16'h2222, rv, rd);
    acc(K_CWR, 0, 16'h0800, rv, rd);
    acc(K_PRD, 1, 0, rv, rd);
    acc(K_PRD, 1, 0, rv, rd);
    check("R12 R1 clear restarts address phase", {last_rom_addr, rd}, {20'h02222, rom_word(20'h02222)});
    acc(K_CWR, 0, 16'h3333, rv, rd);
    acc(K_CWR, 0, 16'h0800, rv, rd);
    acc(K_CLR, 0, 0, rv, rd);
    acc(K_PRD, 1, 0, rv, rd);
    check("R12 clear drops programming step", rd, rom_word(20'h02223));
  endtask

  task automatic t_ignored;
    logic rv; logic [15:0] rd; int n;
    n = rom_cnt + dram_rd_cnt + dram_wr_cnt + iram_cnt;
    acc(K_PRD, 6, 0, rv, rd);
    check("R13 out-of-range index no read", rv, 1'b0);
    acc(3'd5, 0, 0, rv, rd);
    check("R13 unused kind no read", rv, 1'b0);
    acc(K_PWR, 5, 16'h9999, rv, rd);
    check("R13 ignored requests no memory", 32'(rom_cnt + dram_rd_cnt + dram_wr_cnt + iram_cnt), 32'(n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rom();
    t_dram();
    t_ovr();
    t_cell();
    t_iram();
    t_unmatched();
    t_clear();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule